// File: doc/BRIEF.md
# Matrix least-recently-used frame tracker

This block keeps the recency order of a small, fixed set of page frames and names, at every cycle, the frame that has gone unused the longest. It stores one bit per ordered pair of frames, NUM_FRAMES by NUM_FRAMES in all. When a frame is referenced, its row is filled with ones and then its column is wiped to zeros. After that update, each row read as an unsigned number ranks its frame: the smallest row belongs to the least recently used frame.

The surrounding logic pulses `ref_valid` with the index of each frame it touches. It reads `victim_idx` whenever it needs a frame to evict. `clear` is synchronous and returns the tracker to its starting state, for example when a new address space is loaded. The victim output needs no handshake. It is a combinational search over the registered matrix, so it always holds a legal frame index.

The control has two named conditions. HOLD covers cycles with neither `clear` nor `ref_valid`, and the matrix does not change. UPDATE covers cycles with `ref_valid` and no `clear`, and the matrix takes the row-set, column-clear step. A cycle with `clear` is a WIPE and takes priority over both. NUM_FRAMES defaults to 4 and may be set anywhere from 1 to 8.

Top module: `lru_matrix_tracker`

## Requirements
- R1: After reset, and in the cycle after `clear`, every matrix bit is zero and `victim_idx` reads 0.
- R2: A reference to frame k sets every bit of row k to one except the diagonal bit (k,k), which ends at zero, so row k then holds exactly NUM_FRAMES-1 ones.
- R3: A reference to frame k clears column k in every row. The frame referenced most recently is therefore never reported as victim when NUM_FRAMES > 1.
- R4: `victim_idx` names the row with the smallest unsigned value, where column 0 is the most significant bit of a row. In behavioural terms, this is the lowest-index frame never referenced since the last wipe, or, if all frames have been referenced, the one referenced longest ago.
- R5: When several rows share the smallest value (for example after a wipe), the lowest frame index among them is reported.
- R6: A reference changes `victim_idx` only from the clock edge that samples it onward. In a cycle with neither `clear` nor `ref_valid`, the matrix and `victim_idx` stay unchanged.
- R7: When `clear` and `ref_valid` are high in the same cycle, the clear wins and the reference leaves no trace.
- R8: With four frames, after a wipe, the reference order 0,1,2,3,2,1,0,3,2,3 leaves frame 1 as the victim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the matrix |
| clear | input | 1 | Synchronous wipe of the whole matrix |
| ref_valid | input | 1 | A frame is referenced this cycle |
| ref_idx | input | IDX_W | Index of the referenced frame (IDX_W = clog2 of NUM_FRAMES, at least 1) |
| victim_idx | output | IDX_W | Index of the least recently used frame |

## Verification
The assertions assume that reset is applied before the first reference and that `ref_idx` names an existing frame whenever `ref_valid` is high. The check that the most recent frame is never the victim also relies on there being more than one frame. The bench keeps within these limits. It asserts reset at time zero, builds every index from two bits for a four-frame instance, and changes inputs only on the falling clock edge. Its expected victim comes from a per-frame reference timestamp rather than from a matrix, so the row ordering and tie rule are checked against an independent description of recency.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Largest frame count the tracker is sized for.
    localparam int LRU_MAX_FRAMES = 8;

    // Bit position of column `col` inside a row vector: column 0 is the MSB.
    function automatic int col_pos(input int n, input int col);
        return n - 1 - col;
    endfunction

    // Width of a frame index, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lru_row_update.sv
module lru_row_update #(
    parameter int NUM_FRAMES = 4,
    parameter int ROW_ID     = 0,
    localparam int IDX_W     = lru_pkg::idx_width(NUM_FRAMES)
) (
    input  logic                  hit_valid,
    input  logic [IDX_W-1:0]      hit_idx,
    input  logic [NUM_FRAMES-1:0] row_cur,
    output logic [NUM_FRAMES-1:0] row_nxt
);

    localparam logic [IDX_W-1:0] ROW_SEL = IDX_W'(ROW_ID);

    // Row set first, column clear second, so the diagonal ends at zero.
    always_comb begin
        row_nxt = row_cur;
        if (hit_valid) begin
            if (hit_idx == ROW_SEL) begin
                row_nxt = '1;
            end
            for (int c = 0; c < NUM_FRAMES; c++) begin
                if (hit_idx == IDX_W'(c)) begin
                    row_nxt[lru_pkg::col_pos(NUM_FRAMES, c)] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/lru_matrix_store.sv
module lru_matrix_store #(
    parameter int NUM_FRAMES = 4,
    localparam int IDX_W     = lru_pkg::idx_width(NUM_FRAMES)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear,
    input  logic                                  ref_valid,
    input  logic [IDX_W-1:0]                      ref_idx,
    output logic [NUM_FRAMES-1:0][NUM_FRAMES-1:0] rows_q
);

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_UPDATE = 2'd1,
        OP_WIPE   = 2'd2
    } op_e;

    op_e op;

    // Operation decode: wipe beats update, update beats hold.
    always_comb begin
        if (clear) begin
            op = OP_WIPE;
        end else if (ref_valid) begin
            op = OP_UPDATE;
        end else begin
            op = OP_HOLD;
        end
    end

    logic [NUM_FRAMES-1:0][NUM_FRAMES-1:0] rows_d;

    for (genvar r = 0; r < NUM_FRAMES; r++) begin : g_row
        logic [NUM_FRAMES-1:0] row_upd;

        lru_row_update #(
            .NUM_FRAMES (NUM_FRAMES),
            .ROW_ID     (r)
        ) u_row_update (
            .hit_valid (op == OP_UPDATE),
            .hit_idx   (ref_idx),
            .row_cur   (rows_q[r]),
            .row_nxt   (row_upd)
        );

        always_comb begin
            unique case (op)
                OP_WIPE:   rows_d[r] = '0;
                OP_UPDATE: rows_d[r] = row_upd;
                default:   rows_d[r] = rows_q[r];
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rows_q[r] <= '0;
            end else begin
                rows_q[r] <= rows_d[r];
            end
        end
    end

endmodule

// File: rtl/lru_min_search.sv
module lru_min_search #(
    parameter int NUM_FRAMES = 4,
    localparam int IDX_W     = lru_pkg::idx_width(NUM_FRAMES)
) (
    input  logic [NUM_FRAMES-1:0][NUM_FRAMES-1:0] rows,
    output logic [IDX_W-1:0]                      min_idx
);

    logic [NUM_FRAMES-1:0] best_val;

    // Strict less-than keeps the earliest (lowest) index on a tie.
    always_comb begin
        best_val = rows[0];
        min_idx  = '0;
        for (int r = 1; r < NUM_FRAMES; r++) begin
            if (rows[r] < best_val) begin
                best_val = rows[r];
                min_idx  = IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
    parameter int NUM_FRAMES = 4,
    localparam int IDX_W     = lru_pkg::idx_width(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_idx,
    output logic [IDX_W-1:0] victim_idx
);

    logic [NUM_FRAMES-1:0][NUM_FRAMES-1:0] rows_q;
    logic [NUM_FRAMES*NUM_FRAMES-1:0]      mat_flat;

    lru_matrix_store #(
        .NUM_FRAMES (NUM_FRAMES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .ref_valid (ref_valid),
        .ref_idx   (ref_idx),
        .rows_q    (rows_q)
    );

    lru_min_search #(
        .NUM_FRAMES (NUM_FRAMES)
    ) u_search (
        .rows    (rows_q),
        .min_idx (victim_idx)
    );

    // Row r occupies bits [r*NUM_FRAMES +: NUM_FRAMES].
    assign mat_flat = rows_q;

endmodule

// File: rtl/lru_tracker_chk.sv
module lru_tracker_chk #(
    parameter int NUM_FRAMES = 4,
    localparam int IDX_W     = lru_pkg::idx_width(NUM_FRAMES)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             clear,
    input logic                             ref_valid,
    input logic [IDX_W-1:0]                 ref_idx,
    input logic [IDX_W-1:0]                 victim_idx,
    input logic [NUM_FRAMES*NUM_FRAMES-1:0] mat_flat
);

    logic [NUM_FRAMES-1:0] row_of [NUM_FRAMES];
    logic [NUM_FRAMES-1:0] diag;

    always_comb begin
        for (int r = 0; r < NUM_FRAMES; r++) begin
            row_of[r] = mat_flat[r*NUM_FRAMES +: NUM_FRAMES];
            diag[r]   = row_of[r][NUM_FRAMES-1-r];
        end
    end

    a_r1_clear_matrix: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mat_flat == '0 && victim_idx == '0));

    a_r2_row_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !clear) |=>
            ($countones(row_of[$past(ref_idx)]) == NUM_FRAMES - 1));

    a_r2_diag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        diag == '0);

    if (NUM_FRAMES > 1) begin : g_recent
        a_r3_recent_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_valid && !clear) |=> (victim_idx != $past(ref_idx)));
    end

    a_r4_victim_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(victim_idx) < NUM_FRAMES);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_valid && !clear) |=> ($stable(mat_flat) && $stable(victim_idx)));

endmodule

bind lru_matrix_tracker lru_tracker_chk #(
    .NUM_FRAMES (NUM_FRAMES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .ref_valid  (ref_valid),
    .ref_idx    (ref_idx),
    .victim_idx (victim_idx),
    .mat_flat   (mat_flat)
);

// File: tb/lru_matrix_tracker_bench.sv
module lru_matrix_tracker_bench;

    localparam int N     = 4;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clear = 1'b0;
    logic             ref_valid = 1'b0;
    logic [IDX_W-1:0] ref_idx = '0;
    logic [IDX_W-1:0] victim_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model: last-reference stamp per frame, 0 = never since the last wipe.
    int stamp [N];
    int now_t = 0;

    always #5 clk = ~clk;

    lru_matrix_tracker #(.NUM_FRAMES(N)) u_lru_matrix_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .ref_valid  (ref_valid),
        .ref_idx    (ref_idx),
        .victim_idx (victim_idx)
    );

    function automatic int model_victim();
        int best = 0;
        for (int f = 1; f < N; f++) begin
            if (stamp[f] < stamp[best]) best = f;
        end
        return best;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_wipe();
        for (int f = 0; f < N; f++) stamp[f] = 0;
    endtask

    // Drive one cycle at the falling edge, then update the model after the rising edge.
    task automatic apply(input bit v, input int idx, input bit c);
        @(negedge clk);
        ref_valid = v;
        ref_idx   = IDX_W'(idx);
        clear     = c;
        @(posedge clk);
        #1;
        if (c) begin
            model_wipe();
        end else if (v) begin
            now_t++;
            stamp[idx] = now_t;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seq [10] = '{0, 1, 2, 3, 2, 1, 0, 3, 2, 3};
        logic [15:0] lfsr = 16'hACE1;
        int held;

        model_wipe();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset victim", int'(victim_idx), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: ties after a wipe report the lowest index
        apply(0, 0, 1);
        check("R1 clear victim", int'(victim_idx), 0);
        apply(1, 0, 0);
        check("R5 tie lowest index", int'(victim_idx), 1);

        // R2: row of the referenced frame outranks all others
        apply(0, 0, 1);
        apply(1, 3, 0);
        apply(1, 2, 0);
        apply(1, 1, 0);
        apply(1, 0, 0);
        check("R2 full reverse order", int'(victim_idx), 3);

        // R8: the worked example
        apply(0, 0, 1);
        for (int i = 0; i < 10; i++) apply(1, seq[i], 0);
        check("R8 example victim", int'(victim_idx), 1);
        check("R8 model agrees", model_victim(), 1);

        // R6: victim unchanged before the edge that samples a reference
        held = int'(victim_idx);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_idx   = 2'd1;
        clear     = 1'b0;
        #1;
        check("R6 no change before edge", int'(victim_idx), held);
        @(posedge clk);
        #1;
        now_t++;
        stamp[1] = now_t;
        check("R6 change after edge", int'(victim_idx), model_victim());

        // R6: idle cycles hold the victim
        held = int'(victim_idx);
        for (int i = 0; i < 5; i++) begin
            apply(0, 3, 0);
            check("R6 idle hold", int'(victim_idx), held);
        end

        // R7: clear together with a reference
        apply(1, 1, 0);
        apply(1, 2, 1);
        check("R7 clear wins", int'(victim_idx), 0);
        apply(1, 0, 0);
        check("R7 reference left no trace", int'(victim_idx), 1);

        // R3/R4: every sequence of five references over four frames
        for (int s = 0; s < 1024; s++) begin
            apply(0, 0, 1);
            for (int p = 0; p < 5; p++) begin
                int idx;
                idx = (s >> (2 * p)) & 3;
                apply(1, idx, 0);
                check("R4 sweep victim", int'(victim_idx), model_victim());
                check("R3 recent not victim", (int'(victim_idx) != idx) ? 1 : 0, 1);
            end
        end

        // R4/R6/R7: long mixed stream with idles and wipes
        for (int i = 0; i < 3000; i++) begin
            bit v;
            bit c;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = (lfsr[9:5] == 5'd0);
            v = (lfsr[4:2] != 3'd0);
            apply(v, int'(lfsr[1:0]), c);
            check("R4 stream victim", int'(victim_idx), model_victim());
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule